// File: doc/BRIEF.md
# Calendar Counter Chain with Coherent Read Snapshot

This block keeps the time of day and the calendar for a bus-attached real-time clock. A 100 Hz tick-enable drives a chain of eight binary byte counters: hundredths, seconds, minutes, hours, day of week, date, month and year. Each counter's carry advances the next one. Hours run in either a 24-hour format or a 12-hour format with a meridiem flag. The date rollover follows the month length, and February gets a leap day in years divisible by four.

Software reaches the counters through a small byte-wide register port with eight addresses. A read of the hundredths address copies the seven slower counters into a snapshot, so a multi-byte read of the time stays coherent. A tick that lands during a read or a write is held back until the access ends. The block also emits one-cycle pulses on every hundredth, every tenth, and every second, minute, hour and day carry, for an interrupt controller to use.

Top module: `rtc_calendar_chain`

## Requirements
- R1: After synchronous reset the counters hold these values: hundredths 0, seconds 0, minutes 0, day of week 0, date 1, month 1, year 0. Hours hold 0 when `hour24`=1, or 0Ch (12 AM) when `hour24`=0. `rdata` and all pulse outputs are 0.
- R2: A tick advances hundredths by one only while `run`=1. A tick that arrives while `run`=0 leaves every counter unchanged.
- R3: Hundredths wrap 99→0, and seconds and minutes wrap 59→0. Each wrap advances the next counter: hundredths→seconds, seconds→minutes, minutes→hours.
- R4: With `hour24`=1, hours count 0..23. A wrap from 23 to 0 produces a day carry, which advances day of week (0..6, wrapping 6→0) and date.
- R5: With `hour24`=0, bits 4:0 of the hours byte hold 1..12 and bit 7 is the PM flag (1 = PM). Hours step 11→12 and toggle the PM flag, then step 12→1. The day carry happens only at 11 PM→12 AM.
- R6: Date wraps to 1 after the last day of the month, and that wrap advances the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when year mod 4 = 0, and 28 days otherwise. All other months have 31 days. Month wraps 12→1 and advances the year. Year wraps 99→0.
- R7: Register addresses: 0 hundredths, 1 hours, 2 minutes, 3 seconds, 4 month, 5 date, 6 year, 7 day of week. A write stores `wdata` ANDed with the field mask. The masks are 7Fh for hundredths and year, 3Fh for minutes and seconds, 1Fh for date and for hours in 24-hour mode, 9Fh for hours in 12-hour mode, 0Fh for month and 07h for day of week. Masked-off bits read as 0.
- R8: The first cycle of a read strobe at address 0 copies the seven slower counters into a snapshot. Reads of addresses 1..7 return the snapshot until address 0 is read again. Address 0 always returns the live hundredths.
- R9: A tick that arrives while `rd` or `wr_en` is high is applied in the first cycle after the access ends. Any further ticks during the same access are dropped, so the counters advance at most once per access.
- R10: `pulse_hund` fires once per applied tick. `pulse_tenth` fires when hundredths steps from a value ending in 9. `pulse_sec`, `pulse_min`, `pulse_hour` and `pulse_day` fire on the hundredths, seconds, minutes and hours carries. Each pulse is registered, so it appears in the cycle in which the new counter values are visible.
- R11: `rdata` is registered. It shows the addressed byte in the cycle after `rd` is sampled high, and it is 0 while `rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 Hz tick-enable, one cycle wide |
| run | input | 1 | 1 lets the chain count, 0 holds it |
| hour24 | input | 1 | 1 selects 24-hour format, 0 selects 12-hour format |
| rd | input | 1 | Read strobe, level-sensitive |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pulse_hund | output | 1 | Hundredths increment pulse |
| pulse_tenth | output | 1 | Tenths pulse |
| pulse_sec | output | 1 | Seconds increment pulse |
| pulse_min | output | 1 | Minutes increment pulse |
| pulse_hour | output | 1 | Hours increment pulse |
| pulse_day | output | 1 | Day increment pulse |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 3-bit address and top counts of 99 for hundredths and year. With these values the full carry cascade is reachable: every vector preloads a state one tick short of a boundary, so a single tick crosses it. That covers the New Year's Eve wrap, the February leap and non-leap cases, the 30-day months and all three 12-hour transitions in a few dozen cycles. The snapshot test lets 100 ticks pass between reads, so the live seconds counter moves away from the latched copy.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NFIELD = 8;

  typedef enum logic [2:0] {
    F_HUND = 3'd0,
    F_HOUR = 3'd1,
    F_MIN  = 3'd2,
    F_SEC  = 3'd3,
    F_MON  = 3'd4,
    F_DATE = 3'd5,
    F_YEAR = 3'd6,
    F_DOW  = 3'd7
  } field_e;

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                       month_len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:    month_len = 8'd30;
      default:                    month_len = 8'd31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input logic [2:0] f, input logic h24);
    case (f)
      F_HUND, F_YEAR: field_mask = 8'h7F;
      F_MIN, F_SEC:   field_mask = 8'h3F;
      F_HOUR:         field_mask = h24 ? 8'h1F : 8'h9F;
      F_DATE:         field_mask = 8'h1F;
      F_MON:          field_mask = 8'h0F;
      default:        field_mask = 8'h07;
    endcase
  endfunction

  function automatic int field_floor(input int f);
    field_floor = (f == int'(F_DATE) || f == int'(F_MON)) ? 1 : 0;
  endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic busy,
  input  logic run,
  output logic step
);
  logic pending;

  assign step = run && !busy && (tick || pending);

  always_ff @(posedge clk) begin
    if (rst)       pending <= 1'b0;
    else if (busy) pending <= pending || tick;
    else           pending <= 1'b0;
  end

  AST_DEFER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy && tick) && !busy && run) |-> step); // R9

endmodule

// File: rtl/rtc_field_ctr.sv
module rtc_field_ctr #(
  parameter int W       = 8,
  parameter int RST_VAL = 0,
  parameter int LO      = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] RST_Q = W'(RST_VAL);
  localparam logic [W-1:0] LO_Q  = W'(LO);

  assign wrap = inc && (q >= top_val);

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_Q;
    else if (ld)  q <= ld_val;
    else if (inc) q <= wrap ? LO_Q : q + 1'b1;
  end

  AST_FIELD_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q < top_val) |=> (q == $past(q) + 1'b1)); // R3

  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q == top_val) |=> (q == LO_Q)); // R6

endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         h24,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [4:0] LAST24 = 5'd23;
  localparam logic [4:0] NOON   = 5'd12;

  logic       pm;
  logic [4:0] hv;
  logic [W-1:0] nxt;

  assign pm = q[W-1];
  assign hv = q[4:0];
  assign wrap = inc && (h24 ? (hv >= LAST24) : (pm && hv == 5'd11));

  always_comb begin
    nxt = '0;
    if (h24) begin
      nxt[4:0] = (hv >= LAST24) ? 5'd0 : hv + 5'd1;
    end else if (hv == 5'd11) begin
      nxt[W-1] = !pm;
      nxt[4:0] = NOON;
    end else if (hv >= NOON) begin
      nxt[W-1] = pm;
      nxt[4:0] = 5'd1;
    end else begin
      nxt[W-1] = pm;
      nxt[4:0] = hv + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= h24 ? '0 : W'(NOON);
    else if (ld)  q <= ld_val;
    else if (inc) q <= nxt;
  end

  AST_HOUR24_WRAP: assert property (@(posedge clk) disable iff (rst)
    (h24 && inc && !ld && q == W'(23)) |=> (q == '0)); // R4

  AST_HOUR12_MERIDIEM: assert property (@(posedge clk) disable iff (rst)
    (!h24 && inc && !ld && hv == 5'd11) |=> (q[W-1] != $past(q[W-1]))); // R5

endmodule

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int HUND_MAX = 99,
  parameter int YEAR_MAX = 99
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              hour24,
  input  logic              rd,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pulse_hund,
  output logic              pulse_tenth,
  output logic              pulse_sec,
  output logic              pulse_min,
  output logic              pulse_hour,
  output logic              pulse_day
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] fq    [NREG];
  logic [DATA_W-1:0] top_v [NREG];
  logic [DATA_W-1:0] snap  [NREG];
  logic [NREG-1:0]   inc_v, wrap_v, ld_v;
  logic [DATA_W-1:0] ld_val;
  logic step, busy, rd_q, rd_rise, day_carry;

  assign busy    = rd || wr_en;
  assign rd_rise = rd && !rd_q;
  assign ld_val  = wdata & DATA_W'(field_mask(3'(addr), hour24));

  rtc_tick_gate u_gate (
    .clk(clk), .rst(rst), .tick(tick), .busy(busy), .run(run), .step(step)
  );

  // carry cascade in counting order
  assign day_carry = wrap_v[F_HOUR];
  always_comb begin
    inc_v         = '0;
    inc_v[F_HUND] = step;
    inc_v[F_SEC]  = wrap_v[F_HUND];
    inc_v[F_MIN]  = wrap_v[F_SEC];
    inc_v[F_HOUR] = wrap_v[F_MIN];
    inc_v[F_DOW]  = day_carry;
    inc_v[F_DATE] = day_carry;
    inc_v[F_MON]  = wrap_v[F_DATE];
    inc_v[F_YEAR] = wrap_v[F_MON];
    for (int i = 0; i < NREG; i++) top_v[i] = '0;
    top_v[F_HUND] = DATA_W'(HUND_MAX);
    top_v[F_SEC]  = DATA_W'(59);
    top_v[F_MIN]  = DATA_W'(59);
    top_v[F_DOW]  = DATA_W'(6);
    top_v[F_DATE] = DATA_W'(month_len(8'(fq[F_MON]), 8'(fq[F_YEAR])));
    top_v[F_MON]  = DATA_W'(12);
    top_v[F_YEAR] = DATA_W'(YEAR_MAX);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_fld
    assign ld_v[i] = wr_en && (addr == ADDR_W'(i));
    if (i == int'(F_HOUR)) begin : g_hour
      rtc_hour_ctr #(.W(DATA_W)) u_ctr (
        .clk(clk), .rst(rst), .h24(hour24), .inc(inc_v[i]), .ld(ld_v[i]),
        .ld_val(ld_val), .q(fq[i]), .wrap(wrap_v[i])
      );
    end else begin : g_plain
      rtc_field_ctr #(.W(DATA_W), .RST_VAL(field_floor(i)), .LO(field_floor(i))) u_ctr (
        .clk(clk), .rst(rst), .inc(inc_v[i]), .ld(ld_v[i]), .ld_val(ld_val),
        .top_val(top_v[i]), .q(fq[i]), .wrap(wrap_v[i])
      );
    end
  end

  // snapshot latch and registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      rdata <= '0;
      for (int i = 0; i < NREG; i++) snap[i] <= '0;
    end else begin
      rd_q <= rd;
      if (rd_rise && addr == '0)
        for (int i = 1; i < NREG; i++) snap[i] <= fq[i];
      if (!rd)             rdata <= '0;
      else if (addr == '0) rdata <= fq[F_HUND];
      else                 rdata <= snap[addr];
    end
  end

  // registered increment pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      {pulse_hund, pulse_tenth, pulse_sec, pulse_min, pulse_hour, pulse_day} <= '0;
    end else begin
      pulse_hund  <= step;
      pulse_tenth <= step && (fq[F_HUND] % DATA_W'(10) == DATA_W'(9));
      pulse_sec   <= wrap_v[F_HUND];
      pulse_min   <= wrap_v[F_SEC];
      pulse_hour  <= wrap_v[F_MIN];
      pulse_day   <= day_carry;
    end
  end

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(fq[F_HUND])); // R2

  AST_READ_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr_en) |=> $stable(fq[F_HUND])); // R9

  AST_TENTH_ALIGN: assert property (@(posedge clk) disable iff (rst)
    pulse_tenth |-> (fq[F_HUND] % DATA_W'(10) == '0)); // R10

  AST_MIN_EDGE: assert property (@(posedge clk) disable iff (rst)
    pulse_min |-> (fq[F_SEC] == '0 && fq[F_HUND] == '0)); // R3

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd && addr == '0) |=> $stable(snap[F_SEC])); // R8

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0)); // R11

endmodule

// File: tb/sim_rtc_calendar_chain.sv
module sim_rtc_calendar_chain;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, run = 1'b0, hour24 = 1'b1;
  logic rd = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic pulse_hund, pulse_tenth, pulse_sec, pulse_min, pulse_hour, pulse_day;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar_chain u0 (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .hour24(hour24),
    .rd(rd), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pulse_hund(pulse_hund), .pulse_tenth(pulse_tenth), .pulse_sec(pulse_sec),
    .pulse_min(pulse_min), .pulse_hour(pulse_hour), .pulse_day(pulse_day)
  );

  // field order in pre/exp: hund, hour, min, sec, month, date, year, dow (address order)
  // pls bits: {day, hour, min, sec, tenth, hund}
  typedef struct packed {
    logic             h24;
    logic [0:7][7:0]  pre;
    logic [0:7][7:0]  exp;
    logic [5:0]       pls;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, {8'd5, 8'd10, 8'd20, 8'd30, 8'd6, 8'd5, 8'd21, 8'd2},
            {8'd6, 8'd10, 8'd20, 8'd30, 8'd6, 8'd5, 8'd21, 8'd2}, 6'b000001},
    '{1'b1, {8'd9, 8'd10, 8'd20, 8'd30, 8'd6, 8'd5, 8'd21, 8'd2},
            {8'd10, 8'd10, 8'd20, 8'd30, 8'd6, 8'd5, 8'd21, 8'd2}, 6'b000011},
    '{1'b1, {8'd99, 8'd10, 8'd10, 8'd59, 8'd6, 8'd5, 8'd21, 8'd2},
            {8'd0, 8'd10, 8'd11, 8'd0, 8'd6, 8'd5, 8'd21, 8'd2}, 6'b001111},
    '{1'b1, {8'd99, 8'd23, 8'd59, 8'd59, 8'd12, 8'd31, 8'd99, 8'd6},
            {8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0}, 6'b111111},
    '{1'b1, {8'd99, 8'd23, 8'd59, 8'd59, 8'd2, 8'd28, 8'd24, 8'd3},
            {8'd0, 8'd0, 8'd0, 8'd0, 8'd2, 8'd29, 8'd24, 8'd4}, 6'b111111},
    '{1'b1, {8'd99, 8'd23, 8'd59, 8'd59, 8'd2, 8'd28, 8'd23, 8'd3},
            {8'd0, 8'd0, 8'd0, 8'd0, 8'd3, 8'd1, 8'd23, 8'd4}, 6'b111111},
    '{1'b1, {8'd99, 8'd23, 8'd59, 8'd59, 8'd4, 8'd30, 8'd23, 8'd1},
            {8'd0, 8'd0, 8'd0, 8'd0, 8'd5, 8'd1, 8'd23, 8'd2}, 6'b111111},
    '{1'b1, {8'd99, 8'd23, 8'd59, 8'd59, 8'd2, 8'd29, 8'd24, 8'd5},
            {8'd0, 8'd0, 8'd0, 8'd0, 8'd3, 8'd1, 8'd24, 8'd6}, 6'b111111},
    '{1'b0, {8'd99, 8'h0B, 8'd59, 8'd59, 8'd7, 8'd10, 8'd22, 8'd2},
            {8'd0, 8'h8C, 8'd0, 8'd0, 8'd7, 8'd10, 8'd22, 8'd2}, 6'b011111},
    '{1'b0, {8'd99, 8'h8C, 8'd59, 8'd59, 8'd7, 8'd10, 8'd22, 8'd2},
            {8'd0, 8'h81, 8'd0, 8'd0, 8'd7, 8'd10, 8'd22, 8'd2}, 6'b011111},
    '{1'b0, {8'd99, 8'h8B, 8'd59, 8'd59, 8'd7, 8'd10, 8'd22, 8'd2},
            {8'd0, 8'h0C, 8'd0, 8'd0, 8'd7, 8'd11, 8'd22, 8'd3}, 6'b111111},
    '{1'b1, {8'h85, 8'hE5, 8'hC3, 8'hC7, 8'hF3, 8'hE4, 8'h8A, 8'hF9},
            {8'd6, 8'd5, 8'd3, 8'd7, 8'd3, 8'd4, 8'h0A, 8'd1}, 6'b000001}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); d = rdata; rd = 1'b0;
  endtask

  task automatic tick_once(output logic [5:0] p);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    p = {pulse_day, pulse_hour, pulse_min, pulse_sec, pulse_tenth, pulse_hund};
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [5:0] p;
    logic [7:0] rst_exp [8];
    rst_exp = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 pulses", {2'b0, pulse_day, pulse_hour, pulse_min, pulse_sec, pulse_tenth, pulse_hund}, 8'd0);
    chk("R1 rdata", rdata, 8'd0);
    for (int a = 0; a < 8; a++) begin
      rdreg(3'(a), v);
      chk("R1 field", v, rst_exp[a]);
    end
    chk("R11 idle rdata", rdata, 8'd0);

    // table walk: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      hour24 = VEC[i].h24;
      run = 1'b0;
      for (int a = 0; a < 8; a++) wr(3'(a), VEC[i].pre[a]);
      run = 1'b1;
      tick_once(p);
      run = 1'b0;
      chk("R10 pulses", {2'b0, p}, {2'b0, VEC[i].pls});
      for (int a = 0; a < 8; a++) begin
        rdreg(3'(a), v);
        chk((i == NV - 1) ? "R7 masked write" : (VEC[i].h24 ? "R6 field" : "R5 field"), v, VEC[i].exp[a]);
      end
    end

    // R2: tick ignored while stopped
    hour24 = 1'b1;
    wr(3'd0, 8'd40);
    tick_once(p);
    chk("R2 no pulse when stopped", {2'b0, p}, 8'd0);
    rdreg(3'd0, v);
    chk("R2 hold when stopped", v, 8'd40);

    // R8: snapshot coherence
    wr(3'd0, 8'd50);
    wr(3'd3, 8'd10);
    run = 1'b1;
    rdreg(3'd0, v);
    chk("R8 live hundredths", v, 8'd50);
    for (int k = 0; k < 100; k++) tick_once(p);
    rdreg(3'd3, v);
    chk("R8 latched seconds", v, 8'd10);
    rdreg(3'd0, v);
    chk("R8 live hundredths after 100", v, 8'd50);
    rdreg(3'd3, v);
    chk("R8 refreshed seconds", v, 8'd11);

    // R9: deferral during read
    wr(3'd0, 8'd20);
    @(negedge clk); rd = 1'b1; addr = 3'd1; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R9 no pulse during read", {7'b0, pulse_hund}, 8'd0);
    @(negedge clk);
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
    chk("R9 pulse after read", {7'b0, pulse_hund}, 8'd1);
    rdreg(3'd0, v);
    chk("R9 deferred tick applied", v, 8'd21);
    // two ticks inside one strobe advance only once
    @(negedge clk); rd = 1'b1; addr = 3'd2; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
    rdreg(3'd0, v);
    chk("R9 extra tick dropped", v, 8'd22);
    // tick during write
    @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 8'd7; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    chk("R9 no pulse during write", {7'b0, pulse_hund}, 8'd0);
    @(negedge clk);
    chk("R9 pulse after write", {7'b0, pulse_hund}, 8'd1);
    run = 1'b0;
    rdreg(3'd0, v);
    chk("R9 write-deferred tick", v, 8'd23);
    rdreg(3'd2, v);
    chk("R7 minutes written", v, 8'd7);
    @(negedge clk);
    chk("R11 idle rdata after read", rdata, 8'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule